// File: doc/BRIEF.md
# Multi-Mode Programmable Interval Counter

This block is a single down-counting timer channel. A byte-wide write port carries two kinds of writes. The first is a control word, which picks one of six counting behaviours. The second is a pair of count bytes, written low byte first and then high byte. The counter advances on a synchronous tick enable, which stands in for the counter clock. A gate input either enables counting while it is high or starts a run on its rising edge, depending on the behaviour chosen. The single output carries the resulting level, pulse or strobe.

The six behaviours are:
- a terminal-count flag;
- a retriggerable one-shot;
- a periodic one-tick low pulse;
- a square wave;
- a strobe started by software;
- a strobe started by the gate.

A status byte can be read at any time. It reports the output level, whether a written count is still waiting to be transferred into the counting element, the access field and the active behaviour. The counter is armed only once both the control word and the full count have been written.

Top module: `ivt_timer`

## Requirements
- R1: After reset, `out_o` is 1 and `status_o` reads 0x80.
- R2: A write with `wr_ctrl_i`=1 takes these fields from the written byte: bits 5:4 are the access field, and bits 3:1 select the behaviour. Bits 7:6 and bit 0 are ignored. After the write, `out_o` is 0 for behaviour 0 and 1 for all other behaviours. `status_o` then reads {out, null=1, access, behaviour, 0} at bits 7, 6, 5:4, 3:1 and 0.
- R3: Behaviour 0 (terminal-count flag). A write of the high count byte drives `out_o` low and restarts the run. The count N is loaded on the first tick after that write. `out_o` rises after N further gated ticks, so it is observed high N+1 ticks after the write, and it stays high.
- R4: In behaviours 0, 2, 3 and 4, ticks are ignored while `gate_i` is 0. In behaviours 2 and 3, `out_o` is held at 1 while `gate_i` is 0. A rising edge of `gate_i` in behaviours 2 and 3 reloads the count and restarts the period.
- R5: Behaviour 1 (one-shot). A rising edge of `gate_i` on a tick loads the count and drives `out_o` low for N ticks. A further rising edge reloads the count and extends the pulse. A count written during a pulse does not change that pulse and is used by the next trigger.
- R6: Behaviour 2 (periodic pulse). `out_o` is low for exactly one tick in every N ticks. The first low tick comes N ticks after the high count byte is written.
- R7: Behaviour 3 (square wave). `out_o` is high for ceil(N/2) ticks and low for floor(N/2) ticks, for N of 2 or more. The first high half is ceil(N/2)+1 ticks long when counted from the count write.
- R8: Behaviour 4 (software strobe). `out_o` goes low for one tick, N+1 ticks after the count write. It then returns high and does not repeat until a new count is written.
- R9: Behaviour 5 (gate strobe). Nothing happens until a rising edge of `gate_i`. `out_o` then goes low for one tick, N+1 ticks after the edge, whatever level `gate_i` has during the count. Each further rising edge repeats the strobe.
- R10: Status bit 6 is set by every count write and by every control write. It is cleared when the count is transferred into the counting element, including the reloads in behaviours 2 and 3.
- R11: A written count of 0 counts as 65536.
- R12: Behaviour codes 6 and 7 act as behaviours 2 and 3, and the status byte reports them as 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Write strobe |
| wr_ctrl_i | input | 1 | 1 selects the control word, 0 selects a count byte |
| wr_data_i | input | BYTE_W | Write data |
| tick_i | input | 1 | Counter clock enable |
| gate_i | input | 1 | Gate input, used as a level or as a rising edge |
| out_o | output | 1 | Counter output |
| status_o | output | 8 | Status byte |

## Verification
In the one-shot behaviour, a gate rising edge and the write of the high count byte can fall on the same clock edge. The bench provokes this by presenting the last byte of a new count in the same cycle as the gate edge. It then checks two things: the pulse lasts for the old count, and the null-count flag stays set. A second trigger must then produce a pulse of the new length and clear the flag. A count written during a periodic run is handled the same way: it is picked up at the next reload rather than at once.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

    localparam int STAT_W = 8;

    typedef enum logic [2:0] {
        M_TCINT   = 3'd0,
        M_ONESHOT = 3'd1,
        M_RATE    = 3'd2,
        M_SQUARE  = 3'd3,
        M_SWSTB   = 3'd4,
        M_HWSTB   = 3'd5
    } ivt_mode_e;

    typedef struct packed {
        logic      out_lvl;
        logic      null_cnt;
        logic [1:0] access;
        ivt_mode_e mode;
        logic      bcd;
    } ivt_status_t;

    // codes x1x collapse onto the periodic behaviours
    function automatic ivt_mode_e decode_mode(input logic [2:0] code);
        if (code[1]) return ivt_mode_e'({1'b0, code[1:0]});
        return ivt_mode_e'(code);
    endfunction

    function automatic logic init_level(input ivt_mode_e m);
        return (m != M_TCINT);
    endfunction

    function automatic logic gate_forces_high(input ivt_mode_e m);
        return (m == M_RATE) || (m == M_SQUARE);
    endfunction

    function automatic logic edge_started(input ivt_mode_e m);
        return (m == M_ONESHOT) || (m == M_HWSTB);
    endfunction

endpackage

// File: rtl/ivt_regs.sv
module ivt_regs
    import ivt_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int CNT_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_ctrl,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              load_done,
    input  logic              out_lvl,
    output logic              ctrl_wr,
    output ivt_mode_e         mode_new,
    output ivt_mode_e         mode_q,
    output logic              cnt_done,
    output logic [CNT_W-1:0]  count_q,
    output logic              armed_q,
    output logic              newcnt_q,
    output logic [STAT_W-1:0] status
);

    logic [1:0]        access_q;
    logic [BYTE_W-1:0] lo_q;
    logic              hi_phase_q;
    logic              null_q;
    logic              byte_wr;
    ivt_status_t       stat;

    assign ctrl_wr  = wr_en & wr_ctrl;
    assign byte_wr  = wr_en & ~wr_ctrl;
    assign cnt_done = byte_wr & hi_phase_q;
    assign mode_new = decode_mode(wr_data[3:1]);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q     <= M_TCINT;
            access_q   <= 2'b00;
            lo_q       <= '0;
            hi_phase_q <= 1'b0;
            count_q    <= '0;
            armed_q    <= 1'b0;
            newcnt_q   <= 1'b0;
            null_q     <= 1'b0;
        end else if (ctrl_wr) begin
            mode_q     <= mode_new;
            access_q   <= wr_data[5:4];
            hi_phase_q <= 1'b0;
            armed_q    <= 1'b0;
            newcnt_q   <= 1'b0;
            null_q     <= 1'b1;
        end else begin
            if (byte_wr) begin
                if (!hi_phase_q) begin
                    lo_q       <= wr_data;
                    hi_phase_q <= 1'b1;
                end else begin
                    count_q    <= {wr_data, lo_q};
                    hi_phase_q <= 1'b0;
                    armed_q    <= 1'b1;
                end
            end
            if (cnt_done) begin
                newcnt_q <= 1'b1;
                null_q   <= 1'b1;
            end else if (load_done) begin
                newcnt_q <= 1'b0;
                null_q   <= 1'b0;
            end
        end
    end

    always_comb begin
        stat.out_lvl  = out_lvl;
        stat.null_cnt = null_q;
        stat.access   = access_q;
        stat.mode     = mode_q;
        stat.bcd      = 1'b0;
    end
    assign status = stat;

    assert_null_on_count_R10: assert property (@(posedge clk) disable iff (rst)
        cnt_done |=> status[6]);

    assert_null_on_ctrl_R2: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr |=> (status[6] && armed_q == 1'b0));

endmodule

// File: rtl/ivt_gate_edge.sv
module ivt_gate_edge (
    input  logic clk,
    input  logic rst,
    input  logic gate_i,
    input  logic tick,
    input  logic clr,
    output logic gate_lvl,
    output logic trig
);

    logic gate_q;
    logic pend_q;
    logic rise;

    assign rise     = gate_i & ~gate_q;
    assign trig     = pend_q | rise;
    assign gate_lvl = gate_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            gate_q <= gate_i;
            if (clr || tick) pend_q <= 1'b0;
            else if (rise)   pend_q <= 1'b1;
        end
    end

    assert_edge_held_R9: assert property (@(posedge clk) disable iff (rst)
        (rise && !tick && !clr) |=> trig);

endmodule

// File: rtl/ivt_core.sv
module ivt_core
    import ivt_pkg::*;
#(
    parameter int CNT_W = 16,
    localparam int LW = CNT_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             gate_lvl,
    input  logic             trig,
    input  logic             ctrl_wr,
    input  ivt_mode_e        mode_new,
    input  ivt_mode_e        mode,
    input  logic             cnt_done,
    input  logic             armed,
    input  logic             newcnt,
    input  logic [CNT_W-1:0] count,
    output logic             out,
    output logic             load_done
);

    localparam logic [LW-1:0] ONE = LW'(1);
    localparam logic [LW-1:0] TWO = LW'(2);

    logic [LW-1:0] cnt_q, cnt_d;
    logic [LW-1:0] full_n, half_hi, half_lo;
    logic          out_q, out_d;
    logic          run_q, run_d;
    logic          start;

    // a zero count stands for the full range
    assign full_n  = (count == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, count};
    assign half_hi = (full_n + ONE) >> 1;
    assign half_lo = full_n >> 1;

    always_comb begin
        if (edge_started(mode))
            start = trig && armed;
        else if (gate_forces_high(mode))
            start = (newcnt && !run_q) || (trig && armed);
        else
            start = newcnt;
    end

    always_comb begin
        cnt_d     = cnt_q;
        out_d     = out_q;
        run_d     = run_q;
        load_done = 1'b0;
        if (ctrl_wr) begin
            out_d = init_level(mode_new);
            run_d = 1'b0;
        end else if (mode == M_TCINT && cnt_done) begin
            out_d = 1'b0;
            run_d = 1'b0;
        end else begin
            if (tick) begin
                if ((mode inside {M_SWSTB, M_HWSTB}) && !out_q) out_d = 1'b1;
                if (start) begin
                    load_done = 1'b1;
                    run_d     = 1'b1;
                    cnt_d     = (mode == M_SQUARE) ? half_hi : full_n;
                    if (mode == M_ONESHOT)     out_d = 1'b0;
                    else if (mode != M_TCINT)  out_d = 1'b1;
                end else if (run_q && (gate_lvl || edge_started(mode))) begin
                    if (cnt_q == ONE) begin
                        case (mode)
                            M_TCINT, M_ONESHOT: begin
                                out_d = 1'b1;
                                run_d = 1'b0;
                            end
                            M_RATE: begin
                                cnt_d     = full_n;
                                out_d     = 1'b1;
                                load_done = 1'b1;
                            end
                            M_SQUARE: begin
                                if (out_q) begin
                                    out_d = 1'b0;
                                    cnt_d = half_lo;
                                end else begin
                                    out_d     = 1'b1;
                                    cnt_d     = half_hi;
                                    load_done = 1'b1;
                                end
                            end
                            default: begin
                                out_d = 1'b0;
                                run_d = 1'b0;
                            end
                        endcase
                    end else begin
                        cnt_d = cnt_q - ONE;
                        if (mode == M_RATE) out_d = (cnt_q != TWO);
                    end
                end
            end
            if (gate_forces_high(mode) && !gate_lvl) out_d = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            out_q <= 1'b1;
            run_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            out_q <= out_d;
            run_q <= run_d;
        end
    end

    assign out = out_q;

    assert_ctrl_level_R2: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr |=> (out == (mode == M_TCINT ? 1'b0 : 1'b1)));

    assert_flag_needs_tick_R3: assert property (@(posedge clk) disable iff (rst)
        (mode == M_TCINT && !out && !tick && !ctrl_wr) |=> !out);

    assert_gate_low_high_R4: assert property (@(posedge clk) disable iff (rst)
        (gate_forces_high(mode) && !gate_lvl && !ctrl_wr) |=> out);

    assert_strobe_one_tick_R8: assert property (@(posedge clk) disable iff (rst)
        ((mode inside {M_SWSTB, M_HWSTB}) && !out && tick && !ctrl_wr) |=> out);

endmodule

// File: rtl/ivt_timer.sv
module ivt_timer
    import ivt_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int CNT_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_i,
    input  logic              wr_ctrl_i,
    input  logic [BYTE_W-1:0] wr_data_i,
    input  logic              tick_i,
    input  logic              gate_i,
    output logic              out_o,
    output logic [STAT_W-1:0] status_o
);

    logic             ctrl_wr, cnt_done, armed, newcnt, load_done;
    logic             gate_lvl, trig, out_lvl;
    ivt_mode_e        mode_new, mode_q;
    logic [CNT_W-1:0] count_q;

    ivt_regs #(.BYTE_W(BYTE_W)) regs_i (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en_i),
        .wr_ctrl   (wr_ctrl_i),
        .wr_data   (wr_data_i),
        .load_done (load_done),
        .out_lvl   (out_lvl),
        .ctrl_wr   (ctrl_wr),
        .mode_new  (mode_new),
        .mode_q    (mode_q),
        .cnt_done  (cnt_done),
        .count_q   (count_q),
        .armed_q   (armed),
        .newcnt_q  (newcnt),
        .status    (status_o)
    );

    ivt_gate_edge gate_i0 (
        .clk      (clk),
        .rst      (rst),
        .gate_i   (gate_i),
        .tick     (tick_i),
        .clr      (ctrl_wr),
        .gate_lvl (gate_lvl),
        .trig     (trig)
    );

    ivt_core #(.CNT_W(CNT_W)) core_i (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick_i),
        .gate_lvl  (gate_lvl),
        .trig      (trig),
        .ctrl_wr   (ctrl_wr),
        .mode_new  (mode_new),
        .mode      (mode_q),
        .cnt_done  (cnt_done),
        .armed     (armed),
        .newcnt    (newcnt),
        .count     (count_q),
        .out       (out_lvl),
        .load_done (load_done)
    );

    assign out_o = out_lvl;

endmodule

// File: tb/ivt_timer_tb_top.sv
module ivt_timer_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic       wr_ctrl = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       tick = 1'b1;
    logic       gate = 1'b0;
    logic       out;
    logic [7:0] status;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    ivt_timer dut_i (
        .clk       (clk),
        .rst       (rst),
        .wr_en_i   (wr_en),
        .wr_ctrl_i (wr_ctrl),
        .wr_data_i (wr_data),
        .tick_i    (tick),
        .gate_i    (gate),
        .out_o     (out),
        .status_o  (status)
    );

    task automatic chk_eq(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input bit c, input logic [7:0] d);
        wr_en = 1'b1; wr_ctrl = c; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_ctrl = 1'b0;
    endtask

    // access field 11, behaviour code in bits 3:1
    task automatic set_mode(input int m);
        logic [2:0] c;
        c = m[2:0];
        wr(1'b1, {2'b00, 2'b11, c, 1'b0});
    endtask

    task automatic load(input int n);
        logic [15:0] v;
        v = n[15:0];
        wr(1'b0, v[7:0]);
        wr(1'b0, v[15:8]);
    endtask

    task automatic wait_lvl(input logic lvl, input int max, output int k);
        k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (out !== lvl && k < max);
    endtask

    function automatic int exp_status(input int m);
        int em;
        em = (m & 2) != 0 ? (m & 3) : m;
        return ((em != 0) ? 128 : 0) + 64 + 48 + em * 2;
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R-all watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int k;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk_eq("R1 reset out", int'(out), 1);
        chk_eq("R1 reset status", int'(status), 8'h80);

        // behaviour 0 sweep, gate held high
        gate = 1'b1;
        for (int n = 1; n <= 8; n++) begin
            set_mode(0);
            chk_eq("R2 status after control", int'(status), exp_status(0));
            chk_eq("R2 initial low", int'(out), 0);
            load(n);
            chk_eq("R10 null after count", int'(status[6]), 1);
            wait_lvl(1'b1, n + 20, k);
            chk_eq("R3 rise delay", k, n + 1);
            chk_eq("R10 null cleared", int'(status[6]), 0);
            repeat (5) @(negedge clk);
            chk_eq("R3 stays high", int'(out), 1);
        end
        // rewrite mid-count restarts
        set_mode(0);
        load(6);
        repeat (3) @(negedge clk);
        load(4);
        chk_eq("R3 rewrite drops out", int'(out), 0);
        wait_lvl(1'b1, 30, k);
        chk_eq("R3 rewrite restarts", k, 5);

        // gate low suspends behaviour 0
        gate = 1'b0;
        set_mode(0);
        load(4);
        repeat (10) @(negedge clk);
        chk_eq("R4 gate low holds flag", int'(out), 0);
        gate = 1'b1;
        wait_lvl(1'b1, 30, k);
        chk_eq("R4 resume after gate", k, 4);

        // zero count means 65536
        set_mode(0);
        load(0);
        wait_lvl(1'b1, 70000, k);
        chk_eq("R11 zero count length", k, 65537);

        // behaviour 1 sweep
        gate = 1'b0;
        for (int n = 2; n <= 6; n++) begin
            set_mode(1);
            chk_eq("R2 one-shot status", int'(status), exp_status(1));
            load(n);
            repeat (3) @(negedge clk);
            chk_eq("R5 idle until trigger", int'(out), 1);
            chk_eq("R10 null until trigger", int'(status[6]), 1);
            gate = 1'b1;
            @(negedge clk);
            chk_eq("R5 pulse starts", int'(out), 0);
            wait_lvl(1'b1, n + 20, k);
            chk_eq("R5 pulse width", k + 1, n + 1);
            chk_eq("R10 null after trigger", int'(status[6]), 0);
            gate = 1'b0;
            @(negedge clk);
        end
        // retrigger extends
        set_mode(1);
        load(6);
        gate = 1'b1;
        @(negedge clk);
        gate = 1'b0;
        @(negedge clk);
        gate = 1'b1;
        wait_lvl(1'b1, 30, k);
        chk_eq("R5 retrigger length", k, 7);
        gate = 1'b0;
        @(negedge clk);
        // new count during a pulse
        set_mode(1);
        load(6);
        gate = 1'b1;
        @(negedge clk);
        gate = 1'b0;
        load(3);
        wait_lvl(1'b1, 30, k);
        chk_eq("R5 pulse unaffected", k, 4);
        chk_eq("R10 null pending", int'(status[6]), 1);
        gate = 1'b1;
        wait_lvl(1'b1, 30, k);
        chk_eq("R5 next trigger uses new count", k, 4);
        gate = 1'b0;
        @(negedge clk);
        // trigger edge and high byte in the same cycle
        set_mode(1);
        load(5);
        wr(1'b0, 8'd9);
        wr_en = 1'b1; wr_ctrl = 1'b0; wr_data = 8'd0; gate = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        wait_lvl(1'b1, 30, k);
        chk_eq("R5 same-cycle uses old count", k + 1, 6);
        chk_eq("R10 same-cycle null kept", int'(status[6]), 1);
        gate = 1'b0;
        @(negedge clk);
        gate = 1'b1;
        wait_lvl(1'b1, 30, k);
        chk_eq("R5 following trigger new count", k, 10);
        chk_eq("R10 null cleared by trigger", int'(status[6]), 0);
        gate = 1'b0;
        @(negedge clk);

        // behaviour 2 sweep, codes 2 and 6
        gate = 1'b1;
        for (int n = 2; n <= 8; n++) begin
            int m;
            m = (n % 2 != 0) ? 2 : 6;
            set_mode(m);
            chk_eq((m == 6) ? "R12 alias 6 status" : "R2 periodic status", int'(status), exp_status(m));
            load(n);
            wait_lvl(1'b0, n + 20, k);
            chk_eq("R6 first low", k, n);
            wait_lvl(1'b1, 20, k);
            chk_eq("R6 low width", k, 1);
            wait_lvl(1'b0, n + 20, k);
            chk_eq("R6 period", k + 1, n);
        end
        // gate low in behaviour 2
        set_mode(2);
        load(5);
        wait_lvl(1'b0, 30, k);
        gate = 1'b0;
        repeat (6) @(negedge clk);
        chk_eq("R4 gate low forces high", int'(out), 1);
        gate = 1'b1;
        wait_lvl(1'b0, 30, k);
        chk_eq("R4 gate edge reloads", k, 5);

        // behaviour 3 sweep, codes 3 and 7
        for (int n = 2; n <= 9; n++) begin
            int m, h, l;
            m = (n % 2 != 0) ? 3 : 7;
            h = (n + 1) / 2;
            l = n / 2;
            set_mode(m);
            chk_eq((m == 7) ? "R12 alias 7 status" : "R2 square status", int'(status), exp_status(m));
            load(n);
            wait_lvl(1'b0, n + 20, k);
            chk_eq("R7 first high half", k, h + 1);
            wait_lvl(1'b1, n + 20, k);
            chk_eq("R7 low half", k, l);
            wait_lvl(1'b0, n + 20, k);
            chk_eq("R7 high half", k, h);
        end

        // behaviour 4 sweep
        for (int n = 1; n <= 6; n++) begin
            set_mode(4);
            chk_eq("R2 strobe status", int'(status), exp_status(4));
            load(n);
            wait_lvl(1'b0, n + 20, k);
            chk_eq("R8 strobe delay", k, n + 1);
            wait_lvl(1'b1, 20, k);
            chk_eq("R8 strobe width", k, 1);
            wait_lvl(1'b0, 2 * n + 4, k);
            chk_eq("R8 no repeat", int'(out), 1);
        end
        gate = 1'b0;
        set_mode(4);
        load(3);
        repeat (8) @(negedge clk);
        chk_eq("R4 strobe held by gate", int'(out), 1);
        gate = 1'b1;
        wait_lvl(1'b0, 30, k);
        chk_eq("R4 strobe resumes", k, 3);

        // behaviour 5 sweep
        gate = 1'b0;
        @(negedge clk);
        for (int n = 1; n <= 6; n++) begin
            set_mode(5);
            chk_eq("R2 gate strobe status", int'(status), exp_status(5));
            load(n);
            repeat (4) @(negedge clk);
            chk_eq("R9 waits for edge", int'(out), 1);
            gate = 1'b1;
            wait_lvl(1'b0, n + 20, k);
            chk_eq("R9 strobe delay", k, n + 1);
            wait_lvl(1'b1, 20, k);
            chk_eq("R9 strobe width", k, 1);
            gate = 1'b0;
            wait_lvl(1'b0, 2 * n + 4, k);
            chk_eq("R9 no repeat without edge", int'(out), 1);
            gate = 1'b1;
            wait_lvl(1'b0, n + 20, k);
            chk_eq("R9 retrigger delay", k, n + 1);
            gate = 1'b0;
            @(negedge clk);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule